// File: doc/BRIEF.md
# Four-Word Linear Diffusion Stage

This block applies a fixed, invertible linear mixing layer to a 128-bit state held as four 32-bit words. The layer uses only rotations, zero-filling left shifts and XORs. The result is registered, so a transfer accepted on one rising clock edge shows up on the outputs after that same edge. The result is then due to be sampled one cycle after it was presented.

A direction input is read on every accepted transfer and picks one of two mappings. One is the forward mixing network. The other is its exact inverse. Forward and inverse transfers can therefore be interleaved back to back. The block sits between the substitution and key-mixing stages of a cipher round datapath. It does none of that work itself: it has no S-boxes, no subkeys and no round control.

The state is made of words 0 to 3. Word 0 is the least significant 32 bits of the 128-bit state. Every rotation and shift works inside a single 32-bit word.

Top module: `lmix_core`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, that edge clears `out_valid` and all four output words to zero.
- R2: `out_valid` after a rising edge equals the `in_valid` value sampled at that edge, so each result comes exactly one cycle after its input.
- R3: With `in_inverse`=0, the forward map is computed in five steps, in this order. Step 1: word 0 becomes rotl(word 0, 13) and word 2 becomes rotl(word 2, 3). Step 2: word 1 becomes word 1 ^ word 0 ^ word 2, and word 3 becomes word 3 ^ word 2 ^ (word 0 << 3). Step 3: word 1 becomes rotl(word 1, 1) and word 3 becomes rotl(word 3, 7). Step 4: word 0 becomes word 0 ^ word 1 ^ word 3, and word 2 becomes word 2 ^ word 3 ^ (word 1 << 7). Step 5: word 0 becomes rotl(word 0, 5) and word 2 becomes rotl(word 2, 22). The input 0x00000001,0,0,0 (words 0..3) gives 0x100C0000, 0x00004000, 0x00002800, 0x00800000.
- R4: With `in_inverse`=1, the block computes the inverse map. It runs the R3 steps backwards: it rotates right by the same amounts, and its XOR steps use the same left shifts by 3 and 7.
- R5: Passing any state through the forward map and then feeding the result through the inverse map returns the original four words.
- R6: The shifts by 3 and by 7 are logical and fill with zeros. They are not rotations. An all-ones input in the forward direction gives 0xFFFF8FFF, 0xFFFFFFFF, 0x003FFFFF, 0xFFFFFC7F.
- R7: At an edge where `in_valid` is low, the four output words keep their previous values, whatever the data and direction inputs are.
- R8: The direction is taken from each accepted transfer on its own. Forward and inverse transfers on consecutive cycles each produce their own correct result.
- R9: An all-zero state maps to an all-zero state in both directions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Transfer strobe; data and direction are taken when high |
| in_inverse | input | 1 | 0 selects the forward map, 1 the inverse map |
| in_w0 | input | 32 | State word 0 (state bits 31:0) |
| in_w1 | input | 32 | State word 1 |
| in_w2 | input | 32 | State word 2 |
| in_w3 | input | 32 | State word 3 (state bits 127:96) |
| out_valid | output | 1 | High for one cycle per accepted transfer |
| out_w0 | output | 32 | Result word 0 |
| out_w1 | output | 32 | Result word 1 |
| out_w2 | output | 32 | Result word 2 |
| out_w3 | output | 32 | Result word 3 |

## Verification
All results come out after a single register. `out_valid` and the words for a transfer driven before a rising edge are due right after that edge. The bench drives its inputs on falling edges and samples on the next falling edge, which is half a cycle after the capturing edge. For the round trip, each forward result is read back and then presented again as an inverse transfer on the following cycle. The check for held outputs samples one cycle after a low strobe that came with changed data.

// File: rtl/lmix_pkg.sv
// lmix_pkg: shared types and word helpers for the linear diffusion stage.
// Assumes every rotate amount is in 1..WORD_W-1.
package lmix_pkg;
    localparam int WORD_W  = 32;
    localparam int N_WORDS = 4;

    typedef logic [WORD_W-1:0] word_t;
    // Index 0 is the least significant word of the 128-bit state.
    typedef logic [N_WORDS-1:0][WORD_W-1:0] state_t;

    function automatic word_t rol(input word_t v, input int n);
        return (v << n) | (v >> (WORD_W - n));
    endfunction

    function automatic word_t ror(input word_t v, input int n);
        return (v >> n) | (v << (WORD_W - n));
    endfunction
endpackage

// File: rtl/lmix_fwd.sv
// lmix_fwd: combinational forward diffusion network over four words.
// Assumes the rotate and shift amounts are legal for lmix_pkg::rol.
module lmix_fwd
    import lmix_pkg::*;
#(
    parameter int ROT_A = 13,
    parameter int ROT_B = 3,
    parameter int ROT_C = 1,
    parameter int ROT_D = 7,
    parameter int ROT_E = 5,
    parameter int ROT_F = 22,
    parameter int SHL_1 = 3,
    parameter int SHL_2 = 7
) (
    input  state_t st_i,
    output state_t st_o
);
    word_t a0, a2, b1, b3, c1, c3, d0, d2;

    // Five steps: rotate, cross-XOR, rotate, cross-XOR, rotate.
    always_comb begin
        a0 = rol(st_i[0], ROT_A);
        a2 = rol(st_i[2], ROT_B);
        b1 = st_i[1] ^ a0 ^ a2;
        b3 = st_i[3] ^ a2 ^ (a0 << SHL_1);
        c1 = rol(b1, ROT_C);
        c3 = rol(b3, ROT_D);
        d0 = a0 ^ c1 ^ c3;
        d2 = a2 ^ c3 ^ (c1 << SHL_2);
        st_o[0] = rol(d0, ROT_E);
        st_o[1] = c1;
        st_o[2] = rol(d2, ROT_F);
        st_o[3] = c3;
    end
endmodule

// File: rtl/lmix_inv.sv
// lmix_inv: combinational inverse of lmix_fwd; must share its parameters.
// Assumes the same amounts as the forward instance.
module lmix_inv
    import lmix_pkg::*;
#(
    parameter int ROT_A = 13,
    parameter int ROT_B = 3,
    parameter int ROT_C = 1,
    parameter int ROT_D = 7,
    parameter int ROT_E = 5,
    parameter int ROT_F = 22,
    parameter int SHL_1 = 3,
    parameter int SHL_2 = 7
) (
    input  state_t st_i,
    output state_t st_o
);
    word_t u0, u2, v0, v2, w1, w3, x1, x3;

    // Undo the forward steps from last to first.
    always_comb begin
        u0 = ror(st_i[0], ROT_E);
        u2 = ror(st_i[2], ROT_F);
        v2 = u2 ^ st_i[3] ^ (st_i[1] << SHL_2);
        v0 = u0 ^ st_i[1] ^ st_i[3];
        w1 = ror(st_i[1], ROT_C);
        w3 = ror(st_i[3], ROT_D);
        x3 = w3 ^ v2 ^ (v0 << SHL_1);
        x1 = w1 ^ v0 ^ v2;
        st_o[0] = ror(v0, ROT_A);
        st_o[1] = x1;
        st_o[2] = ror(v2, ROT_B);
        st_o[3] = x3;
    end
endmodule

// File: rtl/lmix_core.sv
// lmix_core: registered forward/inverse diffusion stage, one-cycle latency.
// Assumes a synchronous active-low reset; data is captured only with in_valid.
module lmix_core
    import lmix_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        in_valid,
    input  logic        in_inverse,
    input  logic [31:0] in_w0,
    input  logic [31:0] in_w1,
    input  logic [31:0] in_w2,
    input  logic [31:0] in_w3,
    output logic        out_valid,
    output logic [31:0] out_w0,
    output logic [31:0] out_w1,
    output logic [31:0] out_w2,
    output logic [31:0] out_w3
);
    state_t st_in, st_f, st_r, st_sel, st_q;

    // Gather the input words into one state.
    always_comb begin
        st_in[0] = in_w0;
        st_in[1] = in_w1;
        st_in[2] = in_w2;
        st_in[3] = in_w3;
    end

    lmix_fwd u_fwd (.st_i(st_in), .st_o(st_f));
    lmix_inv u_inv (.st_i(st_in), .st_o(st_r));

    // Pick the direction for this transfer.
    always_comb st_sel = in_inverse ? st_r : st_f;

    // Valid flag register.
    always_ff @(posedge clk) begin
        if (!rst_n) out_valid <= 1'b0;
        else        out_valid <= in_valid;
    end

    // One result register per word; each holds while no transfer arrives.
    for (genvar g = 0; g < N_WORDS; g++) begin : g_word
        always_ff @(posedge clk) begin
            if (!rst_n)        st_q[g] <= '0;
            else if (in_valid) st_q[g] <= st_sel[g];
        end
    end

    assign out_w0 = st_q[0];
    assign out_w1 = st_q[1];
    assign out_w2 = st_q[2];
    assign out_w3 = st_q[3];
endmodule

// File: rtl/lmix_core_chk.sv
// lmix_core_chk: protocol and hold checks for lmix_core, attached by bind.
module lmix_core_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        in_valid,
    input logic [31:0] in_w0,
    input logic [31:0] in_w1,
    input logic [31:0] in_w2,
    input logic [31:0] in_w3,
    input logic        out_valid,
    input logic [31:0] out_w0,
    input logic [31:0] out_w1,
    input logic [31:0] out_w2,
    input logic [31:0] out_w3
);
    logic seen_edge = 1'b0;
    logic rst_prev  = 1'b1;

    // Track whether one edge has passed and what reset was at that edge.
    always_ff @(posedge clk) begin
        seen_edge <= 1'b1;
        rst_prev  <= rst_n;
    end

    // After a reset edge everything reads zero.
    always @(negedge clk) begin
        if (seen_edge && !rst_prev)
            assert_reset_clear_R1: assert (!out_valid && out_w0 == 0 && out_w1 == 0
                                           && out_w2 == 0 && out_w3 == 0)
                else $error("reset did not clear outputs");
    end

    assert_valid_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    assert_valid_drops_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);
    assert_hold_words_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(out_w0) && $stable(out_w1) && $stable(out_w2) && $stable(out_w3)));
    assert_zero_maps_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_w0 == 0 && in_w1 == 0 && in_w2 == 0 && in_w3 == 0)
        |=> (out_w0 == 0 && out_w1 == 0 && out_w2 == 0 && out_w3 == 0));
endmodule

bind lmix_core lmix_core_chk u_chk (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
    .in_w0(in_w0), .in_w1(in_w1), .in_w2(in_w2), .in_w3(in_w3),
    .out_valid(out_valid),
    .out_w0(out_w0), .out_w1(out_w1), .out_w2(out_w2), .out_w3(out_w3)
);

// File: tb/tb_lmix_core.sv
module tb_lmix_core;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0, in_inverse = 1'b0;
    logic [31:0] in_w0 = '0, in_w1 = '0, in_w2 = '0, in_w3 = '0;
    logic        out_valid;
    logic [31:0] out_w0, out_w1, out_w2, out_w3;
    int          n_chk = 0, n_err = 0;
    logic [127:0] seen;

    always #5 clk = ~clk;

    lmix_core dut (.*);

    function automatic logic [31:0] rl(input logic [31:0] v, input int n);
        return (v << n) | (v >> (32 - n));
    endfunction
    function automatic logic [31:0] rr(input logic [31:0] v, input int n);
        return (v >> n) | (v << (32 - n));
    endfunction

    // Forward map from the R3 step list.
    function automatic logic [127:0] ref_fwd(input logic [127:0] s);
        logic [31:0] a, b, c, d;
        {d, c, b, a} = s;
        a = rl(a, 13); c = rl(c, 3);
        b = b ^ a ^ c; d = d ^ c ^ (a << 3);
        b = rl(b, 1);  d = rl(d, 7);
        a = a ^ b ^ d; c = c ^ d ^ (b << 7);
        a = rl(a, 5);  c = rl(c, 22);
        return {d, c, b, a};
    endfunction

    // Inverse map: R3 steps reversed (R4).
    function automatic logic [127:0] ref_inv(input logic [127:0] s);
        logic [31:0] a, b, c, d;
        {d, c, b, a} = s;
        a = rr(a, 5);  c = rr(c, 22);
        c = c ^ d ^ (b << 7); a = a ^ b ^ d;
        b = rr(b, 1);  d = rr(d, 7);
        d = d ^ c ^ (a << 3); b = b ^ a ^ c;
        a = rr(a, 13); c = rr(c, 3);
        return {d, c, b, a};
    endfunction

    function automatic logic [127:0] rnd128();
        return {$urandom(), $urandom(), $urandom(), $urandom()};
    endfunction

    task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Drive one transfer at a falling edge, sample at the next falling edge.
    task automatic xfer(input logic v, input logic inv, input logic [127:0] s);
        in_valid = v; in_inverse = inv;
        {in_w3, in_w2, in_w1, in_w0} = s;
        @(negedge clk);
        seen = {out_w3, out_w2, out_w1, out_w0};
    endtask

    initial begin
        #2_000_000;
        n_err++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        logic [127:0] s, f;
        void'($urandom(32'h1A2B3C4D));
        repeat (3) @(negedge clk);
        check("R1 reset", {out_valid, out_w3, out_w2, out_w1, out_w0}, '0);
        rst_n = 1'b1;

        // R3 known answer
        xfer(1, 0, 128'h1);
        check("R3 unit vector", seen, {32'h00800000, 32'h00002800, 32'h00004000, 32'h100C0000});
        check("R2 valid after accept", {127'd0, out_valid}, 128'd1);
        // R6 all ones exposes rotate-instead-of-shift
        xfer(1, 0, '1);
        check("R6 all ones", seen, {32'hFFFFFC7F, 32'h003FFFFF, 32'hFFFFFFFF, 32'hFFFF8FFF});
        xfer(1, 1, {32'hFFFFFC7F, 32'h003FFFFF, 32'hFFFFFFFF, 32'hFFFF8FFF});
        check("R4 inverse of all ones", seen, '1);
        // R9 zero in both directions
        xfer(1, 0, '0);
        check("R9 zero forward", seen, '0);
        xfer(1, 1, '0);
        check("R9 zero inverse", seen, '0);

        // R7 hold: low strobe with new data and direction
        xfer(1, 0, 128'h0123456789ABCDEF_FEDCBA9876543210);
        f = seen;
        xfer(0, 1, rnd128());
        check("R7 hold words", seen, f);
        check("R2 valid low", {127'd0, out_valid}, 128'd0);

        // R3/R4/R8 random, alternating direction back to back
        for (int i = 0; i < 300; i++) begin
            s = rnd128();
            xfer(1, i[0], s);
            if (i[0]) check("R4/R8 inverse random", seen, ref_inv(s));
            else      check("R3/R8 forward random", seen, ref_fwd(s));
        end

        // R5 round trip through the block itself
        for (int i = 0; i < 200; i++) begin
            s = rnd128();
            xfer(1, 0, s);
            f = seen;
            xfer(1, 1, f);
            check("R5 round trip", seen, s);
        end

        // R1 reset mid-stream
        in_valid = 1'b1;
        rst_n = 1'b0;
        @(negedge clk);
        check("R1 reset mid-stream", {out_valid, out_w3, out_w2, out_w1, out_w0}, '0);
        rst_n = 1'b1;
        in_valid = 1'b0;
        @(negedge clk);

        $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule